// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This execution unit performs the integer multiply, high-half multiply, divide and remainder operations of a 64-bit RISC-V core. It also performs the 32-bit word forms of these operations. The core hands it one operation at a time over a valid/ready handshake: an opcode, two 64-bit operands and a destination tag. The unit then works alone for a fixed number of cycles. It presents the result with the tag for a single cycle and is ready again in that same cycle.

Multiplication uses magnitude operands. A product register absorbs a fixed-width slice of the multiplier per cycle, and a final cycle applies the sign. Division uses a restoring divider that produces one quotient bit per cycle. One setup cycle runs before it and one sign fix-up cycle runs after it. Latency depends only on the operation class, never on the operand values. Only one operation is in flight at any time.

Top module: `muldiv_unit`

## Requirements
- R1: `in_ready_o` is high and `busy_o` low while idle. An operation is taken on a rising edge with `in_valid_i` and `in_ready_o` both high. From the next cycle, `in_ready_o` is low and `busy_o` high until the cycle in which `out_valid_o` is high. In that cycle the unit shows ready and not busy.
- R2: Opcode encoding `in_op_i`. Bit 3 selects the 32-bit word form and bit 2 selects divide. Bits [1:0] select the variant. For 64-bit multiply: 0 low product, 1 high signed×signed, 2 high signed×unsigned, 3 high unsigned×unsigned. For divide: 0 signed quotient, 1 unsigned quotient, 2 signed remainder, 3 unsigned remainder. In word multiply, bits [1:0] are ignored.
- R3: A 64-bit multiply returns bits [63:0] of the full 128-bit product, or bits [127:64] under the signedness chosen by the variant.
- R4: A word multiply returns bits [31:0] of the product of the low operand halves, sign-extended from bit 31.
- R5: A result appears `out_valid_o` 6 rising edges after the accepting edge for a 64-bit multiply, and 3 edges after it for a word multiply.
- R6: A 64-bit divide truncates the quotient toward zero. The remainder takes the dividend's sign, and signedness follows the variant.
- R7: A word divide or remainder operates on the low 32 bits of both operands. It returns a 32-bit result sign-extended from bit 31, including for the unsigned variants.
- R8: A result appears 66 rising edges after the accepting edge for a 64-bit divide or remainder, and 34 edges after it for a word divide or remainder.
- R9: Division by zero returns a quotient of all ones and a remainder equal to the dividend. Both follow the width rules of R6 and R7.
- R10: Signed overflow returns the dividend as the quotient and zero as the remainder. Overflow means the most negative value divided by -1, at 64 bits or in word form.
- R11: `out_valid_o` is high for exactly one cycle per accepted operation, and `out_tag_o` then carries that operation's tag. `in_valid_i` while busy has no effect: no extra result appears and no operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Unit can take an operation |
| in_op_i | input | 4 | Opcode, encoded per R2 |
| in_a_i | input | 64 | First operand (multiplicand / dividend) |
| in_b_i | input | 64 | Second operand (multiplier / divisor) |
| in_tag_i | input | TAG_W | Destination tag |
| out_valid_o | output | 1 | Result present, one cycle |
| out_tag_o | output | TAG_W | Tag of the completed operation |
| out_data_o | output | 64 | Result |
| busy_o | output | 1 | Operation in progress |

## Verification
A corrupted latency counter shows up at the ports as a result edge that arrives off the fixed count. It can also show up as a ready that stays low, and the per-operation edge count catches that on the very first operation of the affected class. A wrong step or iteration count in the multiplier or divider only shows in the result value. So does a wrong sign flag. The random mix of signs, widths and extremes exposes these within a few operations. A missed divide-by-zero or overflow path appears as a wrong quotient or remainder, and the directed cases produce that at once.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [3:0] {
    OP_MUL    = 4'h0,
    OP_MULH   = 4'h1,
    OP_MULHSU = 4'h2,
    OP_MULHU  = 4'h3,
    OP_DIV    = 4'h4,
    OP_DIVU   = 4'h5,
    OP_REM    = 4'h6,
    OP_REMU   = 4'h7,
    OP_MULW   = 4'h8,
    OP_DIVW   = 4'hC,
    OP_DIVUW  = 4'hD,
    OP_REMW   = 4'hE,
    OP_REMUW  = 4'hF
  } md_op_e;

  typedef enum logic [1:0] {
    DV_IDLE,
    DV_SETUP,
    DV_ITER
  } dv_phase_e;

  function automatic logic op_word(input logic [3:0] op);
    return op[3];
  endfunction

  function automatic logic op_div(input logic [3:0] op);
    return op[2];
  endfunction

endpackage

// File: rtl/md_mul_seq.sv
module md_mul_seq #(
  parameter int XLEN  = 64,
  parameter int CHUNK = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              word_i,
  input  logic              a_signed_i,
  input  logic              b_signed_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic [2*XLEN-1:0] prod_o
);
  localparam int HW      = XLEN / 2;
  localparam int PW      = 2 * XLEN;
  localparam int SW      = XLEN + CHUNK;
  localparam int STEPS   = XLEN / CHUNK;
  localparam int STEPS_W = STEPS / 2;
  localparam int CW      = $clog2(STEPS + 1);

  logic [XLEN-1:0] mag_a_q;
  logic [PW-1:0]   prod_q;
  logic [CW-1:0]   steps_q;
  logic            fix_q, neg_q;

  logic            a_neg, b_neg;
  logic [XLEN-1:0] a_mag, b_mag;
  logic [SW-1:0]   part, sum;
  logic [PW-1:0]   prod_nx;

  always_comb begin
    a_neg = a_signed_i & a_i[XLEN-1] & ~word_i;
    b_neg = b_signed_i & b_i[XLEN-1] & ~word_i;
    if (word_i) begin
      a_mag = {{HW{1'b0}}, a_i[HW-1:0]};
      b_mag = {{HW{1'b0}}, b_i[HW-1:0]};
    end else begin
      a_mag = a_neg ? -a_i : a_i;
      b_mag = b_neg ? -b_i : b_i;
    end
  end

  // one multiplier slice per step, product shifts right
  always_comb begin
    part    = SW'(mag_a_q) * SW'(prod_q[CHUNK-1:0]);
    sum     = SW'(prod_q[PW-1:XLEN]) + part;
    prod_nx = {sum, prod_q[XLEN-1:CHUNK]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_a_q <= '0;
      prod_q  <= '0;
      steps_q <= '0;
      fix_q   <= 1'b0;
      neg_q   <= 1'b0;
    end else if (start_i) begin
      mag_a_q <= a_mag;
      prod_q  <= {{XLEN{1'b0}}, b_mag};
      steps_q <= word_i ? CW'(STEPS_W) : CW'(STEPS);
      fix_q   <= ~word_i;
      neg_q   <= a_neg ^ b_neg;
    end else if (steps_q != '0) begin
      prod_q  <= prod_nx;
      steps_q <= steps_q - 1'b1;
    end else if (fix_q) begin
      fix_q <= 1'b0;
      if (neg_q) prod_q <= -prod_q;
    end
  end

  assign prod_o = prod_q;

  // R5: previous product fully settled before a new one starts
  a_r5_mul_idle_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (steps_q == '0) && !fix_q);

endmodule

// File: rtl/md_div_seq.sv
module md_div_seq
  import muldiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            word_i,
  input  logic            signed_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);
  localparam int HW = XLEN / 2;
  localparam int CW = $clog2(XLEN + 1);

  dv_phase_e       phase_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN-1:0] raw_a_q, raw_b_q, dvs_q, quo_q, rem_q;
  logic            word_q, sgn_q, qneg_q, rneg_q, dz_q;

  logic            a_neg, b_neg, dz;
  logic [HW-1:0]   a_w_mag, b_w_mag;
  logic [XLEN-1:0] a_mag, b_mag, dvd_load;
  logic [XLEN:0]   rem_sh;
  logic            ge;
  logic [XLEN-1:0] rem_nx, quo_nx;
  logic [XLEN-1:0] q_mag, q_fix, r_fix;

  // setup: magnitudes and special cases
  always_comb begin
    a_neg   = sgn_q & (word_q ? raw_a_q[HW-1] : raw_a_q[XLEN-1]);
    b_neg   = sgn_q & (word_q ? raw_b_q[HW-1] : raw_b_q[XLEN-1]);
    a_w_mag = a_neg ? -raw_a_q[HW-1:0] : raw_a_q[HW-1:0];
    b_w_mag = b_neg ? -raw_b_q[HW-1:0] : raw_b_q[HW-1:0];
    if (word_q) begin
      a_mag    = {{HW{1'b0}}, a_w_mag};
      b_mag    = {{HW{1'b0}}, b_w_mag};
      dvd_load = {a_w_mag, {HW{1'b0}}};
      dz       = (raw_b_q[HW-1:0] == '0);
    end else begin
      a_mag    = a_neg ? -raw_a_q : raw_a_q;
      b_mag    = b_neg ? -raw_b_q : raw_b_q;
      dvd_load = a_mag;
      dz       = (raw_b_q == '0);
    end
  end

  // restoring step
  always_comb begin
    rem_sh = {rem_q, quo_q[XLEN-1]};
    ge     = (rem_sh >= {1'b0, dvs_q});
    rem_nx = ge ? XLEN'(rem_sh - {1'b0, dvs_q}) : rem_sh[XLEN-1:0];
    quo_nx = {quo_q[XLEN-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= DV_IDLE;
      cnt_q   <= '0;
      raw_a_q <= '0;
      raw_b_q <= '0;
      dvs_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      word_q  <= 1'b0;
      sgn_q   <= 1'b0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        DV_IDLE: if (start_i) begin
          raw_a_q <= a_i;
          raw_b_q <= b_i;
          word_q  <= word_i;
          sgn_q   <= signed_i;
          phase_q <= DV_SETUP;
        end
        DV_SETUP: begin
          dvs_q   <= b_mag;
          quo_q   <= dvd_load;
          rem_q   <= '0;
          qneg_q  <= a_neg ^ b_neg;
          rneg_q  <= a_neg;
          dz_q    <= dz;
          cnt_q   <= word_q ? CW'(HW) : CW'(XLEN);
          phase_q <= DV_ITER;
        end
        DV_ITER: begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) phase_q <= DV_IDLE;
        end
        default: phase_q <= DV_IDLE;
      endcase
    end
  end

  // fix-up: sign, zero divisor, width
  always_comb begin
    q_mag = word_q ? {{HW{1'b0}}, quo_q[HW-1:0]} : quo_q;
    q_fix = qneg_q ? -q_mag : q_mag;
    r_fix = rneg_q ? -rem_q : rem_q;
    if (dz_q) begin
      q_fix = '1;
      r_fix = raw_a_q;
    end
    quo_o = word_q ? {{HW{q_fix[HW-1]}}, q_fix[HW-1:0]} : q_fix;
    rem_o = word_q ? {{HW{r_fix[HW-1]}}, r_fix[HW-1:0]} : r_fix;
  end

  // R8: no start while a divide is in progress
  a_r8_div_idle_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> phase_q == DV_IDLE);

  // R6: partial remainder stays below a nonzero divisor
  a_r6_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == DV_ITER && dvs_q != '0) |-> rem_q < dvs_q);

  a_r8_iter_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == DV_ITER) |-> (cnt_q != '0));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int TAG_W     = 5,
  parameter int MUL_CHUNK = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [3:0]       in_op_i,
  input  logic [XLEN-1:0]  in_a_i,
  input  logic [XLEN-1:0]  in_b_i,
  input  logic [TAG_W-1:0] in_tag_i,
  output logic             out_valid_o,
  output logic [TAG_W-1:0] out_tag_o,
  output logic [XLEN-1:0]  out_data_o,
  output logic             busy_o
);
  localparam int HW        = XLEN / 2;
  localparam int PW        = 2 * XLEN;
  localparam int MUL_LAT   = XLEN / MUL_CHUNK + 2;
  localparam int MUL_LAT_W = XLEN / MUL_CHUNK / 2 + 1;
  localparam int DIV_LAT   = XLEN + 2;
  localparam int DIV_LAT_W = HW + 2;
  localparam int CNT_W     = $clog2(DIV_LAT + 1);

  logic             busy_q, out_valid_q;
  logic [CNT_W-1:0] cnt_q, lat_m1;
  logic [3:0]       op_q;
  logic [TAG_W-1:0] tag_q, out_tag_q;
  logic [XLEN-1:0]  out_data_q, res_mux;
  logic             accept;
  logic [PW-1:0]    prod;
  logic [XLEN-1:0]  div_q, div_r;

  assign accept = in_valid_i & ~busy_q;

  always_comb begin
    if (op_div(in_op_i))
      lat_m1 = op_word(in_op_i) ? CNT_W'(DIV_LAT_W - 1) : CNT_W'(DIV_LAT - 1);
    else
      lat_m1 = op_word(in_op_i) ? CNT_W'(MUL_LAT_W - 1) : CNT_W'(MUL_LAT - 1);
  end

  md_mul_seq #(.XLEN(XLEN), .CHUNK(MUL_CHUNK)) u_mul (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept & ~in_op_i[2]),
    .word_i     (in_op_i[3]),
    .a_signed_i (in_op_i[1:0] != 2'b11),
    .b_signed_i (~in_op_i[1]),
    .a_i        (in_a_i),
    .b_i        (in_b_i),
    .prod_o     (prod)
  );

  md_div_seq #(.XLEN(XLEN)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept & in_op_i[2]),
    .word_i   (in_op_i[3]),
    .signed_i (~in_op_i[0]),
    .a_i      (in_a_i),
    .b_i      (in_b_i),
    .quo_o    (div_q),
    .rem_o    (div_r)
  );

  always_comb begin
    if (op_q[2])
      res_mux = op_q[1] ? div_r : div_q;
    else if (op_q[3])
      res_mux = {{HW{prod[XLEN-1]}}, prod[XLEN-1:HW]};
    else if (op_q[1:0] == 2'b00)
      res_mux = prod[XLEN-1:0];
    else
      res_mux = prod[PW-1:XLEN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      op_q        <= '0;
      tag_q       <= '0;
      out_valid_q <= 1'b0;
      out_tag_q   <= '0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= lat_m1;
        op_q   <= in_op_i;
        tag_q  <= in_tag_i;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q      <= 1'b0;
          out_valid_q <= 1'b1;
          out_tag_q   <= tag_q;
          out_data_q  <= res_mux;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign in_ready_o  = ~busy_q;
  assign busy_o      = busy_q;
  assign out_valid_o = out_valid_q;
  assign out_tag_o   = out_tag_q;
  assign out_data_o  = out_data_q;

  a_r1_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (busy_o && !in_ready_o));

  a_r1_ready_at_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (in_ready_o && !busy_o));

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  a_r11_result_ends_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $fell(busy_o));

endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
  localparam int TAG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [3:0]       in_op;
  logic [63:0]      in_a, in_b;
  logic [TAG_W-1:0] in_tag;
  logic             out_valid;
  logic [TAG_W-1:0] out_tag;
  logic [63:0]      out_data;
  logic             busy;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  muldiv_unit #(.XLEN(64), .TAG_W(TAG_W), .MUL_CHUNK(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_op_i(in_op), .in_a_i(in_a), .in_b_i(in_b), .in_tag_i(in_tag),
    .out_valid_o(out_valid), .out_tag_o(out_tag), .out_data_o(out_data),
    .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [3:0] op);
    if (op[2]) return op[3] ? 34 : 66;
    return op[3] ? 3 : 6;
  endfunction

  function automatic string req_of(input logic [3:0] op, input logic [63:0] a,
                                   input logic [63:0] b);
    if (op[2]) begin
      if (op[3]) begin
        if (b[31:0] == 0) return "R9";
        if (!op[0] && a[31:0] == 32'h8000_0000 && b[31:0] == '1) return "R10";
        return "R7";
      end
      if (b == 0) return "R9";
      if (!op[0] && a == 64'h8000_0000_0000_0000 && b == '1) return "R10";
      return "R6";
    end
    return op[3] ? "R4" : "R3";
  endfunction

  function automatic logic [63:0] ref_res(input logic [3:0] op, input logic [63:0] a,
                                          input logic [63:0] b);
    logic [127:0] pa, pb, pp;
    logic [63:0]  p64, q, r;
    logic [31:0]  a32, b32, q32, r32;
    if (!op[2]) begin
      if (op[3]) begin
        p64 = {32'b0, a[31:0]} * {32'b0, b[31:0]};
        return {{32{p64[31]}}, p64[31:0]};
      end
      pa = (op[1:0] != 2'b11) ? {{64{a[63]}}, a} : {64'b0, a};
      pb = (!op[1]) ? {{64{b[63]}}, b} : {64'b0, b};
      pp = pa * pb;
      return (op[1:0] == 2'b00) ? pp[63:0] : pp[127:64];
    end
    if (!op[3]) begin
      if (b == 0) begin q = '1; r = a; end
      else if (!op[0]) begin
        if (a == 64'h8000_0000_0000_0000 && b == '1) begin q = a; r = 0; end
        else begin q = $signed(a) / $signed(b); r = $signed(a) % $signed(b); end
      end else begin q = a / b; r = a % b; end
      return op[1] ? r : q;
    end
    a32 = a[31:0];
    b32 = b[31:0];
    if (b32 == 0) begin q32 = '1; r32 = a32; end
    else if (!op[0]) begin
      if (a32 == 32'h8000_0000 && b32 == '1) begin q32 = a32; r32 = 0; end
      else begin q32 = $signed(a32) / $signed(b32); r32 = $signed(a32) % $signed(b32); end
    end else begin q32 = a32 / b32; r32 = a32 % b32; end
    return op[1] ? {{32{r32[31]}}, r32} : {{32{q32[31]}}, q32};
  endfunction

  task automatic do_op(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [TAG_W-1:0] tag, input bit junk);
    int k;
    logic [63:0] exp;
    exp = ref_res(op, a, b);
    @(negedge clk);
    check(in_ready === 1'b1, "R1", {63'b0, in_ready}, 64'd1, "ready before offer");
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_tag = tag;
    @(posedge clk);
    @(negedge clk);
    check(in_ready === 1'b0 && busy === 1'b1, "R1", {62'b0, in_ready, busy}, 64'd1,
          "ready/busy after accept");
    if (junk) begin
      in_op = 4'($urandom); in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
      in_tag = ~tag;
    end else in_valid = 1'b0;
    k = 0;
    while (k < 100) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (out_valid) break;
      if (junk) begin
        in_valid = 1'($urandom);
        in_a = {$urandom, $urandom};
      end
    end
    in_valid = 1'b0;
    check(k == lat_of(op), op[2] ? "R8" : "R5", 64'(k), 64'(lat_of(op)), "latency");
    check(out_data === exp, req_of(op, a, b), out_data, exp, $sformatf("result op %h", op));
    check(out_tag === tag, "R11", 64'(out_tag), 64'(tag), "tag");
    check(in_ready === 1'b1 && busy === 1'b0, "R1", {62'b0, in_ready, busy}, 64'd2,
          "ready/busy at result");
    @(negedge clk);
    check(out_valid === 1'b0 && busy === 1'b0, "R11", {62'b0, out_valid, busy}, 64'd0,
          junk ? "no effect of valid while busy" : "single result cycle");
  endtask

  function automatic logic [63:0] pick();
    logic [31:0] w;
    case ($urandom_range(0, 6))
      0: return 64'($urandom_range(0, 20));
      1: return -64'($urandom_range(1, 20));
      2: begin w = $urandom; return {{32{w[31]}}, w}; end
      3: case ($urandom_range(0, 5))
           0: return 64'h8000_0000_0000_0000;
           1: return 64'h7fff_ffff_ffff_ffff;
           2: return '1;
           3: return 64'hffff_ffff_8000_0000;
           4: return 64'h0000_0000_ffff_ffff;
           default: return 64'd0;
         endcase
      default: return {$urandom, $urandom};
    endcase
  endfunction

  localparam logic [3:0] OPS [13] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6,
                                      4'h7, 4'h8, 4'hC, 4'hD, 4'hE, 4'hF};

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0; in_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1 && busy === 1'b0 && out_valid === 1'b0, "R1",
          {61'b0, in_ready, busy, out_valid}, 64'd4, "reset state");

    // directed corners
    do_op(4'h0, 64'd3, 64'd5, 5'd1, 1'b0);                              // R3
    do_op(4'h1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 5'd2, 1'b0);
    do_op(4'h2, '1, 64'hffff_ffff_ffff_ffff, 5'd3, 1'b0);               // R3 s*u
    do_op(4'h3, '1, '1, 5'd4, 1'b0);
    do_op(4'h8, 64'h1234_5678_7fff_ffff, 64'd2, 5'd5, 1'b0);            // R4
    do_op(4'h9, 64'd7, 64'd9, 5'd6, 1'b0);                              // R2 word mul variant ignored
    do_op(4'h4, -64'd7, 64'd2, 5'd7, 1'b0);                             // R6 toward zero
    do_op(4'h6, 64'd7, -64'd2, 5'd8, 1'b0);                             // R6 rem sign
    do_op(4'h5, '1, 64'd3, 5'd9, 1'b0);
    do_op(4'h4, -64'd9, 64'd0, 5'd10, 1'b0);                            // R9
    do_op(4'h6, -64'd9, 64'd0, 5'd11, 1'b0);                            // R9
    do_op(4'hC, 64'hdead_beef_0000_0011, 64'hffff_ffff_0000_0000, 5'd12, 1'b0); // R9 word
    do_op(4'h4, 64'h8000_0000_0000_0000, '1, 5'd13, 1'b0);              // R10
    do_op(4'h6, 64'h8000_0000_0000_0000, '1, 5'd14, 1'b0);              // R10
    do_op(4'hC, 64'h0000_0000_8000_0000, 64'h0000_0000_ffff_ffff, 5'd15, 1'b0); // R10 word
    do_op(4'hE, 64'h0000_0000_8000_0000, 64'h0000_0000_ffff_ffff, 5'd16, 1'b0);
    do_op(4'hD, 64'h0000_0000_ffff_ffff, 64'd1, 5'd17, 1'b0);           // R7 sext unsigned
    do_op(4'hF, 64'h1111_1111_ffff_fff0, 64'h9999_9999_0000_0007, 5'd18, 1'b0);
    do_op(4'h4, 64'd1000, 64'd7, 5'd19, 1'b1);                          // R11 junk while busy
    do_op(4'h0, 64'd11, 64'd13, 5'd20, 1'b1);                           // R11 junk while busy

    // random mix, R2 encodings exercised across all codes
    for (int i = 0; i < 400; i++) begin
      do_op(OPS[$urandom_range(0, 12)], pick(), pick(), 5'($urandom), 1'($urandom_range(0, 3) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule